// File: doc/BRIEF.md
# Timed Segment Light Rotator

This block drives one seven-segment digit so that a lit shape travels around the six outer segments in a closed loop. A Moore state machine with twelve states steps through the loop. Six states light a single outer segment. The other six are transition states that light a segment together with the one that follows it. Each single-segment state stays on for a long dwell time. Each transition state stays on for a shorter one. At a 50 MHz clock the long dwell is 120 ms and the short dwell is 35 ms.

A single dwell timer serves every state. It counts clock cycles from the moment a state is entered and clears whenever the state changes. It releases the next step when its count reaches the dwell length minus one, so each state lasts exactly its dwell length in cycles. A stop input holds both the timer and the state, and rotation picks up from the same point once stop falls. Only the state and the timer count are stored in flip-flops. The output pattern is decoded from the state alone. A parameter can add one output register to remove decode glitches, at the cost of one cycle of latency.

Top module: `seg_light_rotator`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the machine returns to the first single-segment state with the dwell count at zero, and `seg` shows 7'b1000000.
- R2: `seg` is active-high with bit 6 = a, 5 = b, 4 = c, 3 = d, 2 = e, 1 = f, 0 = g. The twelve patterns come in this fixed order: a, ab, b, bc, c, cd, d, de, e, ef, f, fa.
- R3: With stop low, each single-segment pattern stays on for exactly `LONG_CYCLES` clock cycles.
- R4: With stop low, each two-segment pattern stays on for exactly `SHORT_CYCLES` clock cycles.
- R5: While `stop` is high at a rising edge, neither the pattern nor the elapsed dwell count changes. This holds even when the count has reached its terminal value.
- R6: After `stop` falls, the current pattern stays on for exactly the number of cycles that were left before the pause.
- R7: Segment g is always off, and the pattern always lights either one or two segments.
- R8: After fa has completed its dwell, the sequence wraps back to the single segment a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stop | input | 1 | High freezes the rotation |
| seg | output | 7 | Segment drive {a,b,c,d,e,f,g}, active high |

## Verification
The assertions check several properties on every cycle. The dwell count never passes the terminal value of the present state. The state moves only when the timer expires and stays put otherwise. A high stop freezes the count. The output never lights g and never lights more than two segments. The bench's scenarios are the only place where the exact dwell lengths, the order of the twelve patterns, the wrap from fa to a, and resumption with the correct remaining time after a pause at an arbitrary point, including the terminal count, become visible.

// File: rtl/lr_pkg.sv
// Package: shared state type and decode functions for the light rotator.
// Assumes segment vector order {a,b,c,d,e,f,g}, active high.
package lr_pkg;

    typedef enum logic [3:0] {
        ST_A  = 4'd0,  ST_AB = 4'd1,
        ST_B  = 4'd2,  ST_BC = 4'd3,
        ST_C  = 4'd4,  ST_CD = 4'd5,
        ST_D  = 4'd6,  ST_DE = 4'd7,
        ST_E  = 4'd8,  ST_EF = 4'd9,
        ST_F  = 4'd10, ST_FA = 4'd11
    } lr_state_t;

    localparam int SEG_W = 7;

    // Successor in the rotation loop (R2, R8).
    function automatic lr_state_t lr_next(input lr_state_t s);
        lr_state_t n;
        case (s)
            ST_A:    n = ST_AB;
            ST_AB:   n = ST_B;
            ST_B:    n = ST_BC;
            ST_BC:   n = ST_C;
            ST_C:    n = ST_CD;
            ST_CD:   n = ST_D;
            ST_D:    n = ST_DE;
            ST_DE:   n = ST_E;
            ST_E:    n = ST_EF;
            ST_EF:   n = ST_F;
            ST_F:    n = ST_FA;
            default: n = ST_A;
        endcase
        return n;
    endfunction

    // Pattern driven in each state (Moore output).
    function automatic logic [SEG_W-1:0] lr_pattern(input lr_state_t s);
        logic [SEG_W-1:0] p;
        case (s)
            ST_A:    p = 7'b1000000;
            ST_AB:   p = 7'b1100000;
            ST_B:    p = 7'b0100000;
            ST_BC:   p = 7'b0110000;
            ST_C:    p = 7'b0010000;
            ST_CD:   p = 7'b0011000;
            ST_D:    p = 7'b0001000;
            ST_DE:   p = 7'b0001100;
            ST_E:    p = 7'b0000100;
            ST_EF:   p = 7'b0000110;
            ST_F:    p = 7'b0000010;
            default: p = 7'b1000010;
        endcase
        return p;
    endfunction

    // True for the two-segment transition states, which use the short dwell.
    function automatic logic lr_is_pair(input lr_state_t s);
        return s[0];
    endfunction

endpackage

// File: rtl/lr_dwell_timer.sv
// Module: shared dwell timer. Counts cycles inside the present state.
// It flags expiry at the terminal count and clears on that same edge.
// It holds its value while hold is high. Assumes the limit changes only
// together with an expiry, so the count never starts above a new limit.
module lr_dwell_timer #(
    parameter int CW = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] count,
    output logic          expire
);

    // Expiry when the terminal count is reached and the timer is not held.
    always_comb begin
        expire = !hold && (count == limit);
    end

    // Count register: clear on reset or expiry, freeze on hold, else increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (expire) begin
            count <= '0;
        end else if (!hold) begin
            count <= count + 1'b1;
        end
    end

    assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= limit);

    assert_hold_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(count));

endmodule

// File: rtl/lr_step_fsm.sv
// Module: state register of the rotator. Moves to the loop successor
// when the timer releases a step, and otherwise holds the present state.
module lr_step_fsm
    import lr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      advance,
    output lr_state_t state
);

    lr_state_t state_nx;

    // Next-state logic: step along the loop on advance.
    always_comb begin
        state_nx = advance ? lr_next(state) : state;
    end

    // State register with synchronous reset to the first segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_A;
        end else begin
            state <= state_nx;
        end
    end

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(state));

    assert_step_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (state != $past(state)));

endmodule

// File: rtl/lr_seg_out.sv
// Module: segment output stage. It decodes the state to a pattern, either
// straight through or through one register stage that removes glitches
// and adds one cycle of latency (chosen by REG_OUT).
module lr_seg_out
    import lr_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lr_state_t        state,
    output logic [SEG_W-1:0] seg
);

    logic [SEG_W-1:0] pat;

    // Pure Moore decode of the present state.
    always_comb begin
        pat = lr_pattern(state);
    end

    generate
        if (REG_OUT) begin : g_reg
            logic [SEG_W-1:0] seg_q;
            // Output register: one-cycle delayed, glitch-free pattern.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    seg_q <= lr_pattern(ST_A);
                end else begin
                    seg_q <= pat;
                end
            end
            assign seg = seg_q;
        end else begin : g_comb
            assign seg = pat;
        end
    endgenerate

endmodule

// File: rtl/seg_light_rotator.sv
// Module: top of the timed segment light rotator. It picks the dwell limit
// of the present state and ties the timer, the state register and the
// output stage together. Assumes both cycle counts are at least 1.
module seg_light_rotator
    import lr_pkg::*;
#(
    parameter int LONG_CYCLES  = 6000000,
    parameter int SHORT_CYCLES = 1750000,
    parameter bit REG_OUT      = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop,
    output logic [6:0] seg
);

    localparam int MAX_CYC = (LONG_CYCLES > SHORT_CYCLES) ? LONG_CYCLES : SHORT_CYCLES;
    localparam int CW      = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
    localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_CYCLES - 1);
    localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_CYCLES - 1);

    lr_state_t     state;
    logic [CW-1:0] limit;
    logic [CW-1:0] count;
    logic          expire;

    // Dwell selection: short for transition states, long for single segments.
    always_comb begin
        limit = lr_is_pair(state) ? SHORT_LIM : LONG_LIM;
    end

    lr_dwell_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (stop),
        .limit  (limit),
        .count  (count),
        .expire (expire)
    );

    lr_step_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (expire),
        .state   (state)
    );

    lr_seg_out #(.REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .seg   (seg)
    );

    assert_g_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seg[0] == 1'b0) && ($countones(seg) >= 1) && ($countones(seg) <= 2));

    assert_stop_no_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> $stable(state));

endmodule

// File: tb/test_seg_light_rotator.sv
module test_seg_light_rotator;

    localparam int LONG  = 9;
    localparam int SHORT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop = 1'b0;
    logic [6:0] seg;

    int total = 0;
    int bad = 0;
    int m_idx = 0;
    int m_cnt = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seg_light_rotator #(.LONG_CYCLES(LONG), .SHORT_CYCLES(SHORT)) i_seg_light_rotator (
        .clk   (clk),
        .rst_n (rst_n),
        .stop  (stop),
        .seg   (seg)
    );

    // Expected pattern for loop position i (R2).
    function automatic logic [6:0] pat(input int i);
        logic [6:0] p = '0;
        int k = i / 2;
        p[6-k] = 1'b1;
        if (i % 2 == 1) p[6-((k+1)%6)] = 1'b1;
        return p;
    endfunction

    function automatic int lim(input int i);
        return (i % 2 == 1) ? SHORT - 1 : LONG - 1;
    endfunction

    task automatic check(input bit ok, input string req, input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: seg=%b expected=%b", req, act, exp);
        end
    endtask

    // One clock with the given stop level; model updated, then compared.
    task automatic tick(input logic s, input string req);
        int prev = m_idx;
        stop = s;
        if (!s) begin
            if (m_cnt == lim(m_idx)) begin
                m_idx = (m_idx + 1) % 12;
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end
        @(negedge clk);
        if (prev == 11 && m_idx == 0)
            check(seg == pat(0), "R8", seg, pat(0));
        else
            check(seg == pat(m_idx), req, seg, pat(m_idx));
        check(seg[0] == 1'b0 && $countones(seg) >= 1 && $countones(seg) <= 2,
              "R7", seg, pat(m_idx));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        stop = 1'($urandom % 2);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        stop = 1'b0;
        m_idx = 0;
        m_cnt = 0;
        check(seg == 7'b1000000, "R1", seg, 7'b1000000);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: seg=%b expected=finish", seg);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();

        // R3: single-segment dwell from reset.
        n = 0;
        do begin tick(1'b0, "R2"); n++; end while (seg == pat(0) && n < 100);
        total++;
        if (n != LONG) begin bad++; $display("FAIL R3: dwell=%0d expected=%0d", n, LONG); end
        // R4: pair dwell that follows.
        n = 0;
        do begin tick(1'b0, "R2"); n++; end while (seg == pat(1) && n < 100);
        total++;
        if (n != SHORT) begin bad++; $display("FAIL R4: dwell=%0d expected=%0d", n, SHORT); end

        // Full loop to cover the wrap (R8).
        for (int i = 0; i < 6*(LONG+SHORT) + 4; i++) tick(1'b0, "R2");

        // R5 at terminal count, then R6 resume.
        do_reset();
        for (int i = 0; i < LONG - 1; i++) tick(1'b0, "R3");
        for (int i = 0; i < 6; i++) tick(1'b1, "R5");
        tick(1'b0, "R6");
        check(seg == pat(1), "R6", seg, pat(1));

        // R6 mid-dwell pause: remaining time preserved.
        do_reset();
        for (int i = 0; i < 3; i++) tick(1'b0, "R3");
        for (int i = 0; i < 5; i++) tick(1'b1, "R5");
        n = 0;
        do begin tick(1'b0, "R6"); n++; end while (seg == pat(0) && n < 100);
        total++;
        if (n != LONG - 3) begin bad++; $display("FAIL R6: remaining=%0d expected=%0d", n, LONG - 3); end

        // Random stop pattern against the model, with an occasional reset.
        for (int i = 0; i < 3000; i++) begin
            if (i == 1500) do_reset();
            tick(1'(($urandom % 4) == 0), "R5");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule